// File: doc/BRIEF.md
# Microcoded Two-Register Stack Datapath

This block is a single-cycle processor core organised around two 16-bit registers that act as the top two stack cells: a top register and a next register. A 4-bit program counter steps through a 16-entry microcode store that is set by a parameter. Each 10-bit word is horizontal, so its fields drive the datapath directly. One bit enables the next-register write and one enables the top-register write. A 2-bit field picks the source for the top register, and a 6-bit field is the function code sent to an arithmetic and logic unit outside the block.

The external unit takes the top register as operand a and the next register as operand b. It returns its result on `fu_y` in the same cycle. The core loads the top register from one of four sources: the next register, the unit result, the zero-extended 8-bit switch input, or zero. When its enable is set, the next register always captures the present top value. Both registers update on the same clock edge, so one word can exchange them, duplicate the top cell or push a fetched value. The counter advances on every clock and the microcode store is read combinationally from it.

Top module: `stack_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter, the top register and the next register all become zero. After that edge, `fu_code` shows the function code of word 0.
- R2: Once out of reset, the program counter rises by one on every clock and wraps from 15 back to 0, so word 0 executes again on the 17th clock.
- R3: `fu_code` equals bits 5:0 of the microword that the current program counter selects.
- R4: When word bit 8 is set, the top register loads the source chosen by bits 7:6: 00 selects the next register, 01 selects `fu_y`, 10 selects `{8'h00, sw_in}`, and 11 selects zero.
- R5: When word bit 9 is set, the next register loads the value the top register held before the edge.
- R6: A word with bits 9 and 8 set and select 00 (0x310) exchanges the two registers on one edge.
- R7: A register whose enable bit is clear keeps its value, whatever the select field and the switch input hold. The all-zero word changes neither register.
- R8: `tos_q` and `nos_q` are the operands a and b of the external unit. A word that loads the top register from `fu_y` without bit 9 leaves the next register unchanged.
- R9: With the default microcode and the external unit applying b+a (0x10), a+1 (0x12), ~a (0x14), b|a (0x16), a<<1 (0x18) and b<<a (0x1C), the top register reads 0069, 0008, 6900, 0037, 6937, D26E, 00A4, D312, 2CED, 2CEE after the ten program steps. The switch input is 69, 08, 37 and A4 at the four fetch steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low clear |
| sw_in | input | 8 | Switch value for the fetch source |
| fu_y | input | 16 | Result returned by the external function unit |
| fu_code | output | 6 | Function code of the current microword |
| tos_q | output | 16 | Top register, operand a and display value |
| nos_q | output | 16 | Next register, operand b |

## Verification
The assertions check the following on every cycle:
- the counter steps by one and wraps;
- both registers clear under reset;
- a register with a clear enable holds its value;
- the next register captures the previous top value;
- a swap word exchanges the two cells;
- the switch source is zero-extended.

Only the bench scenarios can show the rest. These are the arithmetic chain of the default program through a modelled function unit, the zero and next-register sources, the result pushed together with a push, the wrap back into the program's first fetch, and a clear in the middle of a run.

// File: rtl/stack_pkg.sv
// Shared microword layout, source encodings and default microcode.
// Assumes a 10-bit horizontal word: [9] next load, [8] top load,
// [7:6] top source select, [5:0] function code.
package stack_pkg;
    localparam int MW_W  = 10;
    localparam int FC_W  = 6;
    localparam int NPROG = 16;

    typedef enum logic [1:0] {
        SRC_NOS  = 2'b00,
        SRC_FU   = 2'b01,
        SRC_SW   = 2'b10,
        SRC_ZERO = 2'b11
    } tsrc_e;

    typedef struct packed {
        logic            nos_ld;
        logic            tos_ld;
        tsrc_e           tsrc;
        logic [FC_W-1:0] fcode;
    } uword_t;

    localparam logic [MW_W-1:0] UW_NOP    = 10'h000;
    localparam logic [MW_W-1:0] UW_DUP    = 10'h210;
    localparam logic [MW_W-1:0] UW_SWAP   = 10'h310;
    localparam logic [MW_W-1:0] UW_FETCH  = 10'h390;
    localparam logic [MW_W-1:0] UW_ADD    = 10'h150;
    localparam logic [MW_W-1:0] UW_INC    = 10'h152;
    localparam logic [MW_W-1:0] UW_NOT    = 10'h154;
    localparam logic [MW_W-1:0] UW_OR     = 10'h156;
    localparam logic [MW_W-1:0] UW_DBL    = 10'h158;
    localparam logic [MW_W-1:0] UW_SHL    = 10'h15C;

    // Entry 0 is the rightmost field; unused entries are NOP.
    localparam logic [NPROG*MW_W-1:0] DEMO_PROG = {
        UW_NOP, UW_NOP, UW_NOP, UW_NOP, UW_NOP, UW_NOP,
        UW_INC, UW_NOT, UW_ADD, UW_FETCH, UW_DBL,
        UW_OR, UW_FETCH, UW_SHL, UW_FETCH, UW_FETCH
    };
endpackage

// File: rtl/stack_pc.sv
// Program counter: free-running up-counter, wraps at 2**PC_W.
// Assumes synchronous active-low reset to zero.
module stack_pc #(
    parameter int PC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] pc
);
    // Advance one step per clock, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc + 1'b1;
    end

    // R2: step by one, including the wrap to zero.
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pc == $past(pc) + 1'b1);

    // R1: reset forces the counter to zero.
    assert_pc_reset_R1: assert property (@(posedge clk)
        !rst_n |=> pc == '0);
endmodule

// File: rtl/stack_urom.sv
// Microcode store: combinational lookup of a parameter image.
// Assumes PROGRAM holds 2**PC_W words, entry 0 in the low bits.
module stack_urom
    import stack_pkg::*;
#(
    parameter int PC_W = 4,
    parameter int DEPTH = 2 ** PC_W,
    parameter logic [DEPTH*MW_W-1:0] PROGRAM = DEMO_PROG
) (
    input  logic [PC_W-1:0] addr,
    output uword_t          word
);
    // Select the addressed word from the flat image.
    always_comb begin
        word = uword_t'(PROGRAM[addr*MW_W +: MW_W]);
    end
endmodule

// File: rtl/stack_tsrc_mux.sv
// Four-way source select for the top register.
// Assumes SW_W <= DATA_W; the switch value is zero-extended.
module stack_tsrc_mux
    import stack_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SW_W   = 8,
    localparam int PAD_W = DATA_W - SW_W
) (
    input  tsrc_e             sel,
    input  logic [DATA_W-1:0] nos,
    input  logic [DATA_W-1:0] fu,
    input  logic [SW_W-1:0]   sw,
    output logic [DATA_W-1:0] y
);
    // Pick the next-register, unit, switch or zero source.
    always_comb begin
        unique case (sel)
            SRC_NOS:  y = nos;
            SRC_FU:   y = fu;
            SRC_SW:   y = {{PAD_W{1'b0}}, sw};
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/stack_ldreg.sv
// Load-enabled register with synchronous active-low clear.
// Assumes the load is sampled together with data on the rising edge.
module stack_ldreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture d when loading, else hold; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

    // R7: no load, no change.
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !ld) |=> $stable(q));

    // R1: reset clears the register.
    assert_reg_reset_R1: assert property (@(posedge clk)
        !rst_n |=> q == '0);
endmodule

// File: rtl/stack_core.sv
// Two-register stack datapath driven by a horizontal microcode store.
// Assumes the external function unit returns fu_y combinationally
// from fu_code, tos_q (operand a) and nos_q (operand b).
module stack_core
    import stack_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SW_W   = 8,
    parameter int PC_W   = 4,
    localparam int DEPTH = 2 ** PC_W,
    parameter logic [DEPTH*MW_W-1:0] PROGRAM = DEMO_PROG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW_W-1:0]   sw_in,
    input  logic [DATA_W-1:0] fu_y,
    output logic [FC_W-1:0]   fu_code,
    output logic [DATA_W-1:0] tos_q,
    output logic [DATA_W-1:0] nos_q
);
    localparam int PAD_W = DATA_W - SW_W;

    logic [PC_W-1:0]   pc;
    uword_t            uw;
    logic [DATA_W-1:0] tos_d;

    stack_pc #(.PC_W(PC_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .pc(pc)
    );

    stack_urom #(.PC_W(PC_W), .DEPTH(DEPTH), .PROGRAM(PROGRAM)) u_rom (
        .addr(pc), .word(uw)
    );

    stack_tsrc_mux #(.DATA_W(DATA_W), .SW_W(SW_W)) u_mux (
        .sel(uw.tsrc), .nos(nos_q), .fu(fu_y), .sw(sw_in), .y(tos_d)
    );

    stack_ldreg #(.W(DATA_W)) u_tos (
        .clk(clk), .rst_n(rst_n), .ld(uw.tos_ld), .d(tos_d), .q(tos_q)
    );

    stack_ldreg #(.W(DATA_W)) u_nos (
        .clk(clk), .rst_n(rst_n), .ld(uw.nos_ld), .d(tos_q), .q(nos_q)
    );

    // Expose the function field of the current word.
    always_comb begin
        fu_code = uw.fcode;
    end

    // R5: next register takes the old top value.
    assert_nos_from_tos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && uw.nos_ld) |=> nos_q == $past(tos_q));

    // R6: swap word exchanges both cells on one edge.
    assert_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && uw.nos_ld && uw.tos_ld && uw.tsrc == SRC_NOS)
        |=> (tos_q == $past(nos_q)) && (nos_q == $past(tos_q)));

    // R4: switch source arrives zero-extended.
    assert_switch_zext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && uw.tos_ld && uw.tsrc == SRC_SW)
        |=> tos_q == {{PAD_W{1'b0}}, $past(sw_in)});

    // R4: zero source clears the top register.
    assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && uw.tos_ld && uw.tsrc == SRC_ZERO) |=> tos_q == '0);
endmodule

// File: tb/sim_stack_core.sv
`timescale 1ns/1ps
module sim_stack_core;
    import stack_pkg::*;

    localparam int NV = 17;

    // u1 program: exercises every source, swap, dup, push-with-result, hold.
    localparam logic [NPROG*MW_W-1:0] PROG1 = {
        UW_FETCH, UW_NOP, 10'h080, 10'h354,
        UW_ADD, UW_SWAP, UW_FETCH, 10'h200,
        UW_FETCH, 10'h100, 10'h1C0, UW_FETCH,
        UW_DUP, UW_SWAP, UW_FETCH, UW_FETCH
    };

    // {sw, fcode, expected T, expected N}
    localparam logic [47:0] VEC0 [NV] = '{
        48'h69_10_0069_0000, 48'h08_10_0008_0069, 48'h00_1C_6900_0069,
        48'h37_10_0037_6900, 48'h00_16_6937_6900, 48'h00_18_D26E_6900,
        48'hA4_10_00A4_D26E, 48'h00_10_D312_D26E, 48'h00_14_2CED_D26E,
        48'h00_12_2CEE_D26E, 48'h00_00_2CEE_D26E, 48'h00_00_2CEE_D26E,
        48'h00_00_2CEE_D26E, 48'h00_00_2CEE_D26E, 48'h00_00_2CEE_D26E,
        48'h00_00_2CEE_D26E, 48'h5A_10_005A_2CEE
    };
    localparam logic [47:0] VEC1 [NV] = '{
        48'h11_10_0011_0000, 48'h22_10_0022_0011, 48'h00_10_0011_0022,
        48'h00_10_0011_0011, 48'h33_10_0033_0011, 48'h00_00_0000_0011,
        48'h00_00_0011_0011, 48'h44_10_0044_0011, 48'h00_00_0044_0044,
        48'h55_10_0055_0044, 48'h00_10_0044_0055, 48'h00_10_0099_0055,
        48'h00_14_FF66_0099, 48'h77_00_FF66_0099, 48'h00_00_FF66_0099,
        48'h80_10_0080_FF66, 48'h11_10_0011_0080
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sw0 = '0, sw1 = '0;
    logic [15:0] y0, y1, t0, t1, n0, n1;
    logic [5:0]  fc0, fc1;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Bench model of the external function unit.
    function automatic logic [15:0] fu_model(logic [5:0] fc, logic [15:0] a, logic [15:0] b);
        case (fc)
            6'h10:   return b + a;
            6'h12:   return a + 16'd1;
            6'h14:   return ~a;
            6'h16:   return b | a;
            6'h18:   return a << 1;
            6'h1C:   return b << a;
            default: return 16'h0000;
        endcase
    endfunction

    always_comb y0 = fu_model(fc0, t0, n0);
    always_comb y1 = fu_model(fc1, t1, n1);

    stack_core u0 (
        .clk(clk), .rst_n(rst_n), .sw_in(sw0), .fu_y(y0),
        .fu_code(fc0), .tos_q(t0), .nos_q(n0)
    );

    stack_core #(.PROGRAM(PROG1)) u1 (
        .clk(clk), .rst_n(rst_n), .sw_in(sw1), .fu_y(y1),
        .fu_code(fc1), .tos_q(t1), .nos_q(n1)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag0(int i);
        if (i == 16) return "R2 wrap";
        if (i >= 10) return "R7 nop hold";
        return "R9 program";
    endfunction

    function automatic string tag1(int i);
        case (i)
            2, 10:  return "R6 swap";
            3, 8:   return "R5 nos load";
            5:      return "R4 zero src";
            6:      return "R4 nos src";
            11, 12: return "R4 fu src";
            13, 14: return "R7 hold";
            16:     return "R2 wrap";
            default: return "R4 switch src";
        endcase
    endfunction

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, word 0 function code visible.
        chk("R1 reset T", t0, 16'h0000);
        chk("R1 reset N", n0, 16'h0000);
        chk("R1 reset fcode", {10'd0, fc0}, 16'h0010);
        rst_n = 1'b1;

        // Table walk, one step per clock for both instances.
        for (int i = 0; i < NV; i++) begin
            sw0 = VEC0[i][47:40];
            sw1 = VEC1[i][47:40];
            chk("R3 fcode u0", {10'd0, fc0}, {10'd0, VEC0[i][37:32]});
            chk("R3 fcode u1", {10'd0, fc1}, {10'd0, VEC1[i][37:32]});
            @(negedge clk);
            chk(tag0(i), t0, VEC0[i][31:16]);
            chk(i < 10 ? "R8 no pop" : tag0(i), n0, VEC0[i][15:0]);
            chk(tag1(i), t1, VEC1[i][31:16]);
            chk(tag1(i), n1, VEC1[i][15:0]);
        end

        // R8: operand ports equal the register contents driving the unit.
        chk("R8 operand a", t0, 16'h005A);
        chk("R8 operand b", n0, 16'h2CEE);

        // R1: clear in mid-run dominates a pending fetch.
        sw0 = 8'hC3;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 midrun T", t0, 16'h0000);
        chk("R1 midrun N", n0, 16'h0000);
        chk("R1 midrun fcode", {10'd0, fc0}, 16'h0010);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: restart from word 0 (fetch) after clear.
        chk("R2 restart T", t0, 16'h00C3);
        chk("R2 restart N", n0, 16'h0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule